// File: doc/BRIEF.md
# Shared-Term Constant Product Generator

This block multiplies one input sample by a fixed family of constants (11, 15, 29 and 43) and presents all four products at once. It contains no multiplier cells. Every product comes from wired left shifts and two-input adders or subtractors.

The terms 3x and 5x are each built once. All the larger products then reuse them. Built separately, 29x and 43x would take six adders. Sharing the two terms brings that down to four. The 11x product also reuses 3x. The 15x product shows the subtractor path as 16x minus x.

The block has no clock or state, so each output follows the sample in the same cycle. A parameter selects whether the sample is unsigned or two's complement. Every internal node is wide enough to hold the largest constant times the largest sample.

Top module: `shared_const_mult`

## Requirements
- R1: `prod11` equals 11 times the sample, taken modulo 2^14.
- R2: `prod15` equals 15 times the sample modulo 2^14. It is formed by subtracting the sample from the sample shifted left by 4.
- R3: `prod29` equals 29 times the sample modulo 2^14. It is built from the shared terms as (3x shifted left by 3) plus 5x.
- R4: `prod43` equals 43 times the sample modulo 2^14. It is built as (5x shifted left by 3) plus 3x.
- R5: With `IS_SIGNED`=0 the sample is read as 0..255. Each output, read as unsigned, equals the exact product with no wrap. The largest case is 43·255 = 10965.
- R6: With `IS_SIGNED`=1 the sample is read as two's complement in -128..127. Each output is the exact product in 14-bit two's complement. For example, sample 0x80 gives `prod43` = -5504 = 0x2A80.
- R7: A zero sample gives zero on all four outputs.
- R8: The block is purely combinational. The outputs settle to the new products within the same clock period in which the sample changes, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleIn | input | 8 | Sample to be scaled (unsigned or two's complement per `IS_SIGNED`) |
| prod11 | output | 14 | Sample times 11 |
| prod15 | output | 14 | Sample times 15 |
| prod29 | output | 14 | Sample times 29 |
| prod43 | output | 14 | Sample times 43 |

## Verification
The bench sweeps all 256 sample codes through one unsigned instance and one signed instance. It compares every product with a behavioural multiply.

The sweep targets the following corners:
- Codes 0x7F, 0x80 and 0xFF separate the two modes. A wrong sign or zero extension turns 0x80 times 43 into +5504 or a wrapped value instead of -5504.
- Code 0xFF in unsigned mode drives `prod43` to its peak of 10965. An internal node cut one bit short would wrap that value.
- A term shifted by the wrong amount, or a swapped shared term (3x where 5x belongs), mismatches on almost every nonzero code. Zero is checked on its own.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Largest constant in the family; internal nodes are sized from it.
  localparam int MAX_COEF = 43;

  function automatic int bitsFor(input int value);
    return $clog2(value + 1);
  endfunction
endpackage

// File: rtl/spm_shared_terms.sv
// Extends the sample to the internal width and forms the two shared terms.
module spm_shared_terms #(
  parameter int IN_W      = 8,
  parameter int INT_W     = 14,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  sampleIn,
  output logic [INT_W-1:0] xExt,
  output logic [INT_W-1:0] times3,
  output logic [INT_W-1:0] times5
);
  localparam int EXT_W = INT_W - IN_W;

  generate
    if (IS_SIGNED) begin : g_sext
      assign xExt = {{EXT_W{sampleIn[IN_W-1]}}, sampleIn};
    end else begin : g_zext
      assign xExt = {{EXT_W{1'b0}}, sampleIn};
    end
  endgenerate

  // One adder each; reused by every product downstream.
  assign times3 = xExt + (xExt << 1);
  assign times5 = xExt + (xExt << 2);
endmodule

// File: rtl/spm_combiner.sv
// Combines the extended sample and the shared terms into the final products.
module spm_combiner #(
  parameter int INT_W = 14
) (
  input  logic [INT_W-1:0] xExt,
  input  logic [INT_W-1:0] times3,
  input  logic [INT_W-1:0] times5,
  output logic [INT_W-1:0] full11,
  output logic [INT_W-1:0] full15,
  output logic [INT_W-1:0] full29,
  output logic [INT_W-1:0] full43
);
  assign full11 = (xExt << 3) + times3;     // 8x + 3x
  assign full15 = (xExt << 4) - xExt;       // 16x - x
  assign full29 = (times3 << 3) + times5;   // 24x + 5x
  assign full43 = (times5 << 3) + times3;   // 40x + 3x
endmodule

// File: rtl/shared_const_mult.sv
module shared_const_mult #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 14,
  parameter bit IS_SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  sampleIn,
  output logic [OUT_W-1:0] prod11,
  output logic [OUT_W-1:0] prod15,
  output logic [OUT_W-1:0] prod29,
  output logic [OUT_W-1:0] prod43
);
  localparam int NEED_W = IN_W + spm_pkg::bitsFor(spm_pkg::MAX_COEF);
  localparam int INT_W  = (NEED_W > OUT_W) ? NEED_W : OUT_W;

  logic [INT_W-1:0] xExt, times3, times5;
  logic [INT_W-1:0] full11, full15, full29, full43;

  spm_shared_terms #(.IN_W(IN_W), .INT_W(INT_W), .IS_SIGNED(IS_SIGNED)) u_terms (
    .sampleIn(sampleIn), .xExt(xExt), .times3(times3), .times5(times5)
  );

  spm_combiner #(.INT_W(INT_W)) u_comb (
    .xExt(xExt), .times3(times3), .times5(times5),
    .full11(full11), .full15(full15), .full29(full29), .full43(full43)
  );

  assign prod11 = full11[OUT_W-1:0];
  assign prod15 = full15[OUT_W-1:0];
  assign prod29 = full29[OUT_W-1:0];
  assign prod43 = full43[OUT_W-1:0];
endmodule

// File: rtl/spm_check.sv
module spm_check #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 14,
  parameter bit IS_SIGNED = 1'b0
) (
  input logic [IN_W-1:0]  sampleIn,
  input logic [OUT_W-1:0] prod11,
  input logic [OUT_W-1:0] prod15,
  input logic [OUT_W-1:0] prod29,
  input logic [OUT_W-1:0] prod43
);
  int xVal;
  logic [OUT_W-1:0] x14, x26, x40;

  always_comb begin
    xVal = IS_SIGNED ? int'($signed(sampleIn)) : int'(sampleIn);
    x14  = OUT_W'(xVal * 14);
    x26  = OUT_W'(xVal * 26);
    x40  = OUT_W'(xVal * 40);
    if (!$isunknown(sampleIn)) begin
      // R3/R4: gap between the two shared-term products
      p_gap_r4: assert (OUT_W'(prod43 - prod29) == x14)
        else $error("prod43-prod29 mismatch");
      // R1/R3: 11x + 29x = 40x
      p_sum_r1: assert (OUT_W'(prod11 + prod29) == x40)
        else $error("prod11+prod29 mismatch");
      // R2: 15x + 11x = 26x
      p_sub_r2: assert (OUT_W'(prod15 + prod11) == x26)
        else $error("prod15+prod11 mismatch");
      // R7: zero in, zero out
      p_zero_r7: assert (sampleIn != '0 ||
                         (prod11 == '0 && prod15 == '0 && prod29 == '0 && prod43 == '0))
        else $error("nonzero product for zero sample");
      // R5: unsigned products are ordered by constant
      p_no_overflow_r5: assert (IS_SIGNED || (prod11 <= prod15 && prod15 <= prod29 && prod29 <= prod43))
        else $error("unsigned product ordering broken");
    end
  end
endmodule

bind shared_const_mult spm_check #(
  .IN_W(IN_W), .OUT_W(OUT_W), .IS_SIGNED(IS_SIGNED)
) u_chk (.*);

// File: tb/test_shared_const_mult.sv
module test_shared_const_mult;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 8;
  localparam int OUT_W = 14;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] sampleIn = '0;
  logic [OUT_W-1:0] u11, u15, u29, u43;
  logic [OUT_W-1:0] s11, s15, s29, s43;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int pending[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_const_mult #(.IN_W(IN_W), .OUT_W(OUT_W), .IS_SIGNED(1'b0)) i_shared_const_mult (
    .sampleIn(sampleIn), .prod11(u11), .prod15(u15), .prod29(u29), .prod43(u43)
  );

  shared_const_mult #(.IN_W(IN_W), .OUT_W(OUT_W), .IS_SIGNED(1'b1)) i_shared_const_mult_s (
    .sampleIn(sampleIn), .prod11(s11), .prod15(s15), .prod29(s29), .prod43(s43)
  );

  function automatic logic [OUT_W-1:0] refProd(input int code, input int coef, input bit sgn);
    int v;
    v = (sgn && code >= 128) ? code - 256 : code;
    return OUT_W'(v * coef);
  endfunction

  task automatic check(input string req, input int code, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s code=0x%02h actual=0x%04h expected=0x%04h", req, code, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (2) @(posedge clk);
    // R7: zero sample during reset gives zero everywhere
    @(negedge clk);
    check("R7 unsigned p11", 0, u11, '0);
    check("R7 unsigned p15", 0, u15, '0);
    check("R7 unsigned p29", 0, u29, '0);
    check("R7 unsigned p43", 0, u43, '0);
    check("R7 signed p43",   0, s43, '0);
    rst = 1'b0;
    for (int v = 0; v < 256; v++) begin
      @(posedge clk);
      #1 sampleIn = IN_W'(v);
      pending.push_back(v);
      // R8: sampled in the same period the sample changed
      @(negedge clk);
      begin
        int c;
        c = pending.pop_front();
        check("R1/R5 unsigned 11x", c, u11, refProd(c, 11, 1'b0));
        check("R2/R5 unsigned 15x", c, u15, refProd(c, 15, 1'b0));
        check("R3/R5 unsigned 29x", c, u29, refProd(c, 29, 1'b0));
        check("R4/R5 unsigned 43x", c, u43, refProd(c, 43, 1'b0));
        check("R1/R6 signed 11x",   c, s11, refProd(c, 11, 1'b1));
        check("R2/R6 signed 15x",   c, s15, refProd(c, 15, 1'b1));
        check("R3/R6 signed 29x",   c, s29, refProd(c, 29, 1'b1));
        check("R4/R6 signed 43x",   c, s43, refProd(c, 43, 1'b1));
      end
    end
    // Boundary points with explicit constants
    @(posedge clk);
    #1 sampleIn = 8'hFF;
    @(negedge clk);
    check("R5 peak 43*255", 255, u43, 14'd10965);
    check("R6 signed -1*43", 255, s43, 14'h3FD5);
    @(posedge clk);
    #1 sampleIn = 8'h80;
    @(negedge clk);
    check("R6 signed -128*43", 128, s43, 14'h2A80);
    check("R8 unsigned 128*43", 128, u43, 14'd5504);
    @(posedge clk);
    #1 sampleIn = 8'h00;
    @(negedge clk);
    check("R7 zero after sweep", 0, u29 | s29 | u15 | s15, '0);
    summary();
  end
endmodule